// File: doc/BRIEF.md
# March Address Generator with Selectable Column-LSB Order

This block produces the address stream for one or more march sweeps over a memory under test. A start pulse captures the sweep settings. These are the sweep direction, a 3-bit row-count code, a mask of RAMs to visit, one column-LSB order bit per RAM, and a 4-bit data seed. From the next cycle the block issues one address per clock until every selected RAM has been swept once.

The two lowest address bits follow one of two orders. The first is plain binary. The second swaps the last two steps of each group of four, which suits RAMs whose column decode is compiled in that order. The address bits above them count in plain binary and carry once per group of four. Each RAM type has its own order bit, and the bit of the RAM under test is the one applied. The seed is repeated across the whole write-data bus.

Selected RAMs are visited one after another, starting at the lowest set mask bit. The next RAM's first address follows the previous RAM's final address with no idle cycle. Upper-address scrambling is left to the surrounding logic.

Top module: `march_addr_gen`

## Requirements
- R1: After reset, addr_vld, last and addr are 0, wdata is all zeros and ram_id is 0.
- R2: A start pulse while idle and with a nonzero ram_mask makes addr_vld high on the next cycle. From then on one address is issued per cycle with no gap until the last selected RAM's sweep ends, after which addr_vld falls.
- R3: A sweep covers 2^(row_sel+2) addresses, from 4 for code 0 up to 512 for code 7. Address bits above that range are always 0.
- R4: With the active order bit at 0, addr[1:0] runs 00,01,10,11 when counting up and 11,10,01,00 when counting down.
- R5: With the active order bit at 1, addr[1:0] runs 00,01,11,10 when counting up and 10,11,01,00 when counting down.
- R6: addr above bit 1 counts in plain binary and steps once after every complete group of four LSB values. It starts at 0 when counting up (dir_down=0) and at its maximum when counting down (dir_down=1).
- R7: last is high exactly on the final address of each RAM's sweep in the current direction, and never while addr_vld is low.
- R8: lsb_order bit k applies to RAM k, where 0 is the valid RAM, 1 the tag RAM, 2 the parity RAM and 3 the data RAM. ram_id shows the index of the RAM being swept.
- R9: RAMs set in ram_mask are swept serially in ascending index order. Each RAM uses the direction and row count captured at start.
- R10: wdata equals the captured 4-bit seed repeated across all DATA_W bits. It is held unchanged for the whole run.
- R11: A start pulse while a run is active, or with ram_mask equal to 0, is ignored and leaves the address stream and wdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| row_sel | input | 3 | Sweep size code, 2^(row_sel+2) addresses |
| ram_mask | input | 4 | RAMs to sweep, bit k selects RAM k |
| lsb_order | input | 4 | Column-LSB order bit for each RAM |
| seed | input | 4 | Data seed |
| addr | output | 9 | Current sweep address |
| wdata | output | 64 | Replicated seed |
| addr_vld | output | 1 | addr holds a sweep address this cycle |
| last | output | 1 | Final address of the current RAM's sweep |
| ram_id | output | 2 | Index of the RAM being swept |

## Verification
A table of single-RAM runs covers both directions, both LSB orders and row codes from the smallest to the largest. Each entry sets the order bits of the unselected RAMs opposite to the selected one, so taking the order bit from the wrong RAM changes the LSB sequence. The table also exposes carry errors in the upper bits, a wrong sweep length and a misplaced last flag. Directed runs cover a two-RAM mask with differing order bits, which checks the serial order and the seamless hand-over between RAMs. They also cover a start pulse with altered settings in mid-run, which must not disturb the stream, and a start pulse with an empty mask, which must produce no activity.

// File: rtl/march_addr_gen.sv
module march_addr_gen #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 3,
  parameter int RAM_N  = 4,
  parameter int SEED_W = 4,
  localparam int ID_W  = $clog2(RAM_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_down,
  input  logic [SEL_W-1:0]  row_sel,
  input  logic [RAM_N-1:0]  ram_mask,
  input  logic [RAM_N-1:0]  lsb_order,
  input  logic [SEED_W-1:0] seed,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              addr_vld,
  output logic              last,
  output logic [ID_W-1:0]   ram_id
);
  localparam int REP = DATA_W / SEED_W;

  logic              busy;
  logic [ADDR_W-1:0] cnt, lim_q, lim_in;
  logic [RAM_N-1:0]  mask_q, order_q;
  logic              dir_q;
  logic [SEED_W-1:0] seed_q;
  logic [ID_W-1:0]   id_q, first_id, next_id;
  logic              first_vld, next_vld, swap;
  logic [ADDR_W:0]   span;
  int                shamt;

  assign shamt  = (int'(row_sel) + 2 > ADDR_W) ? ADDR_W : int'(row_sel) + 2;
  assign span   = ({{ADDR_W{1'b0}}, 1'b1} << shamt) - 1'b1;
  assign lim_in = span[ADDR_W-1:0];

  always_comb begin
    first_vld = 1'b0;
    first_id  = '0;
    for (int i = RAM_N - 1; i >= 0; i--)
      if (ram_mask[i]) begin
        first_vld = 1'b1;
        first_id  = ID_W'(i);
      end
  end

  always_comb begin
    next_vld = 1'b0;
    next_id  = '0;
    for (int i = RAM_N - 1; i >= 0; i--)
      if (mask_q[i] && i > int'(id_q)) begin
        next_vld = 1'b1;
        next_id  = ID_W'(i);
      end
  end

  assign swap     = order_q[id_q];
  assign last     = busy && (dir_q ? (cnt == '0) : (cnt == lim_q));
  assign addr_vld = busy;
  assign ram_id   = id_q;
  assign wdata    = {REP{seed_q}};
  assign addr     = busy ? {cnt[ADDR_W-1:2], swap ? {cnt[1], cnt[1] ^ cnt[0]} : cnt[1:0]}
                         : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      lim_q   <= '0;
      mask_q  <= '0;
      order_q <= '0;
      dir_q   <= 1'b0;
      seed_q  <= '0;
      id_q    <= '0;
    end else if (!busy) begin
      if (start && first_vld) begin
        busy    <= 1'b1;
        lim_q   <= lim_in;
        mask_q  <= ram_mask;
        order_q <= lsb_order;
        dir_q   <= dir_down;
        seed_q  <= seed;
        id_q    <= first_id;
        cnt     <= dir_down ? lim_in : '0;
      end
    end else if (last) begin
      if (next_vld) begin
        id_q <= next_id;
        cnt  <= dir_q ? lim_q : '0;
      end else begin
        busy <= 1'b0;
      end
    end else begin
      cnt <= dir_q ? cnt - 1'b1 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/march_addr_gen_chk.sv
module march_addr_gen_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 9,
  parameter int SEL_W  = 3,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [SEL_W-1:0]  row_sel,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              addr_vld,
  input logic              last
);
  logic [ADDR_W-1:0] bound;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bound <= '0;
    else if (start && !addr_vld)
      bound <= (int'(row_sel) + 2 >= ADDR_W) ? '1 : ADDR_W'((1 << (int'(row_sel) + 2)) - 1);

  // R2
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !last |=> addr_vld);

  // R7
  end_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_vld) |-> $past(last));

  // R7
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_vld |-> !last);

  // R10
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && $past(addr_vld) |-> $stable(wdata));

  // R3
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> (addr & ~bound) == '0);

  // R4
  lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && $past(addr_vld) && !$past(last) |-> addr[1:0] != $past(addr[1:0]));
endmodule

bind march_addr_gen march_addr_gen_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .row_sel(row_sel),
  .addr(addr), .wdata(wdata), .addr_vld(addr_vld), .last(last)
);

// File: tb/tb_march_addr_gen.sv
module tb_march_addr_gen;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_down = 1'b0;
  logic [2:0]  row_sel = '0;
  logic [3:0]  ram_mask = '0, lsb_order = '0, seed = '0;
  logic [8:0]  addr;
  logic [63:0] wdata;
  logic        addr_vld, last;
  logic [1:0]  ram_id;
  int errors = 0, checks = 0, cycles = 0;

  always #2 clk = ~clk;

  march_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_down(dir_down),
    .row_sel(row_sel), .ram_mask(ram_mask), .lsb_order(lsb_order), .seed(seed),
    .addr(addr), .wdata(wdata), .addr_vld(addr_vld), .last(last), .ram_id(ram_id)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] exp_addr(input int i, input int n, input bit dn, input bit ord);
    int lg = dn ? n - 1 - i : i;
    int lo;
    int map_lin [4] = '{0, 1, 2, 3};
    int map_swp [4] = '{0, 1, 3, 2};
    lo = ord ? map_swp[lg % 4] : map_lin[lg % 4];
    return 9'((lg & ~3) | lo);
  endfunction

  // poke: pulse start with altered settings in mid-run (R11)
  task automatic run(input logic [3:0] m, input logic [3:0] ord, input bit dn,
                     input logic [2:0] rs, input logic [3:0] sd, input bit poke);
    int n = 1 << (int'(rs) + 2);
    bit first = 1'b1;
    @(negedge clk);
    ram_mask = m; lsb_order = ord; dir_down = dn; row_sel = rs; seed = sd; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int r = 0; r < 4; r++) begin
      if (m[r]) begin
        for (int i = 0; i < n; i++) begin
          if (!first) @(negedge clk);
          first = 1'b0;
          if (poke && i == 2 && r == 0) begin
            start = 1'b1; seed = ~sd; dir_down = ~dn; row_sel = 3'd0; ram_mask = 4'b0001;
          end else begin
            start = 1'b0;
          end
          chk(addr_vld == 1'b1, "R2 addr_vld", addr_vld, 1);
          chk(ram_id == 2'(r), "R9 ram_id", ram_id, r);
          chk(addr == exp_addr(i, n, dn, ord[r]), "R4/R5/R6/R8 addr", addr, exp_addr(i, n, dn, ord[r]));
          chk(last == (i == n - 1), "R7 last", last, i == n - 1);
          chk(wdata == {16{sd}}, "R10 wdata", wdata, {16{sd}});
        end
      end
    end
    start = 1'b0;
    @(negedge clk);
    chk(addr_vld == 1'b0, "R2 end of run", addr_vld, 0);
    chk(last == 1'b0, "R7 last idle", last, 0);
  endtask

  // {dir_down, row_sel[2:0], order, seed[3:0]}
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 3'd0, 1'b0, 4'h5},
    {1'b0, 3'd1, 1'b1, 4'hA},
    {1'b1, 3'd0, 1'b0, 4'h3},
    {1'b1, 3'd2, 1'b1, 4'hC},
    {1'b0, 3'd3, 1'b1, 4'h9},
    {1'b1, 3'd3, 1'b0, 4'h6},
    {1'b0, 3'd7, 1'b0, 4'hF},
    {1'b1, 3'd7, 1'b1, 4'h1}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog actual=%0d expected=<100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    chk(addr_vld == 0 && last == 0, "R1 reset flags", {addr_vld, last}, 0);
    chk(addr == 0 && wdata == 0, "R1 reset data", addr, 0);
    chk(ram_id == 0, "R1 reset ram_id", ram_id, 0);
    #10 rst_n = 1'b1;
    // R3 R4 R5 R6 R8: one parity-RAM run per vector, other order bits opposite
    for (int v = 0; v < 8; v++) begin
      logic [8:0] e = VEC[v];
      logic [3:0] ord = e[4] ? 4'b0100 : 4'b1011;
      run(4'b0100, ord, e[8], e[7:5], e[3:0], 1'b0);
    end
    // R9: tag RAM (order 0) then data RAM (order 1)
    run(4'b1010, 4'b1000, 1'b0, 3'd1, 4'h7, 1'b0);
    run(4'b1111, 4'b0101, 1'b1, 3'd0, 4'hB, 1'b0);
    // R11: start while busy ignored
    run(4'b0001, 4'b0000, 1'b0, 3'd1, 4'h2, 1'b1);
    // R11: empty mask ignored
    @(negedge clk);
    ram_mask = 4'b0000; seed = 4'hE; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(addr_vld == 1'b0, "R11 empty mask", addr_vld, 0);
      chk(wdata == {16{4'h2}}, "R11 wdata kept", wdata, {16{4'h2}});
      @(negedge clk);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule